// File: doc/BRIEF.md
# Power Button Sleep-State Controller

This block turns a front-panel power button, a sleep button and a ring-indicate line into sleep-state decisions. All three active-low inputs are synchronised and then debounced against a slow tick. A small state machine tracks the system state (working S0, suspend S1 to S4, soft-off S5, and G3 when main power is absent). Depending on that state, a clean button press becomes one of three things: a request to software (SCI or SMI), a wake event that returns the system to S0, or nothing at all.

A hold-down timer counts ticks while the power button stays pressed in S0. When it reaches the limit it forces the state to S5 at once. This forced shutdown does not depend on power-good or on any handshake. Software asks for a sleep state through a one-cycle command carrying the target state. The debounced button level is available as a status bit. Every event leaves the block as a one-cycle strobe, registered in the same cycle as the state update it goes with.

States and transitions: G3 to S5 on power return; any state to G3 on power loss; S0 to S1..S5 on a software sleep command; S1..S4 to S0 on a wake from the power button, the sleep button or ring indicate; S5 to S0 on a wake from the power button or ring indicate; S0 to S5 on hold-down override.

Top module: `pwrbtn_seq`

## Requirements
- R1: `state_o` encodes S0=0, S1..S4=1..4, S5=5, G3=7. After reset with main power present, the state is 5 and every strobe is low.
- R2: Each input is debounced. The debounced level changes only after the synchronised input has differed from it for DB_TICKS consecutive ticks, so shorter pulses have no effect. `btn_lvl_o` is 1 while the debounced power button is pressed.
- R3: A power-button press in S0 pulses `sci_o` if `sci_en_i` is 1 and pulses `smi_o` otherwise. The state stays S0.
- R4: A power-button press in S1..S5 pulses `wake_o` and the state becomes S0.
- R5: When the power button stays pressed for HOLD_TICKS ticks counted in S0, `ovr_o` pulses and the state becomes S5. This happens whatever the value of `pwr_ok_i`. A continued hold gives only one pulse.
- R6: The hold timer does not advance in S1..S5. It clears when the button is released.
- R7: Losing main power moves the state to G3. In G3, presses give no strobe. When power returns the state is S5, with no wake, even if the button is still held.
- R8: A sleep-button press pulses `slp_req_o` in S0 and wakes the system (`wake_o`, to S0) from S1..S4. In S5 and G3 it has no effect.
- R9: When `ring_en_i` is 1, a ring-indicate press wakes the system from S1..S5 and pulses `brk_irq_o` in S0. When `ring_en_i` is 0 it has no effect.
- R10: A `sw_sleep_i` pulse in S0 with `pwr_ok_i` = 1 moves the state to `sw_typ_i` when that value is 1..5. Any other value, or `pwr_ok_i` = 0, leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| tick_i | input | 1 | slow tick strobe for debounce and hold timing |
| pwr_btn_ni | input | 1 | power button, active low |
| slp_btn_ni | input | 1 | sleep button, active low |
| ring_ni | input | 1 | ring indicate, active low |
| main_pwr_i | input | 1 | main power present (0 = G3) |
| pwr_ok_i | input | 1 | power good; gates software sleep commands |
| sci_en_i | input | 1 | selects SCI (1) or SMI (0) for S0 presses |
| ring_en_i | input | 1 | enables ring-indicate events |
| sw_sleep_i | input | 1 | software sleep command strobe |
| sw_typ_i | input | 3 | target state code for the sleep command |
| state_o | output | 3 | current state code |
| btn_lvl_o | output | 1 | debounced power-button level, 1 = pressed |
| sci_o | output | 1 | SCI request strobe |
| smi_o | output | 1 | SMI request strobe |
| wake_o | output | 1 | wake event strobe |
| ovr_o | output | 1 | hold-down override strobe |
| slp_req_o | output | 1 | sleep-button request strobe |
| brk_irq_o | output | 1 | ring-indicate break-event interrupt strobe |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse. They also assume that `main_pwr_i` drops only as a level change and that software issues sleep commands as single-cycle pulses. The bench generates a tick on every fourth clock and changes every input on the falling edge. Each button action lasts either well below the debounce window or well beyond it, never close to it, so the expected strobe counts are fixed. Every long hold is either clearly shorter or clearly longer than the override limit.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [2:0] {
        ST_S0 = 3'd0,
        ST_S1 = 3'd1,
        ST_S2 = 3'd2,
        ST_S3 = 3'd3,
        ST_S4 = 3'd4,
        ST_S5 = 3'd5,
        ST_G3 = 3'd7
    } pstate_e;

    localparam int SRC_PWR  = 0;
    localparam int SRC_SLP  = 1;
    localparam int SRC_RING = 2;
    localparam int NSRC     = 3;

    function automatic logic valid_sleep(input logic [2:0] typ);
        return (typ >= 3'd1) && (typ <= 3'd5);
    endfunction
endpackage

// File: rtl/pbs_debounce.sv
module pbs_debounce #(
    parameter int DB_TICKS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic raw_ni,
    output logic lvl_o,
    output logic press_o
);
    localparam int CW = $clog2(DB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

    logic [1:0]    sync_q;
    logic          stable_q;
    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic          raw;

    assign raw = sync_q[1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q   <= 2'b11;
            stable_q <= 1'b1;
            prev_q   <= 1'b1;
            cnt_q    <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_ni};
            prev_q <= stable_q;
            if (raw == stable_q) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == LAST) begin
                    stable_q <= raw;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign lvl_o   = ~stable_q;
    assign press_o = prev_q & ~stable_q;

    // R2: the filtered level moves only on a tick
    p_db_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(stable_q));

    // R2: an input that agrees with the level never disturbs it
    p_db_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raw == stable_q) |=> $stable(stable_q));
endmodule

// File: rtl/pbs_hold.sv
module pbs_hold #(
    parameter int HOLD_TICKS = 4000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic pressed_i,
    input  logic run_i,
    output logic fire_o
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);
    localparam logic [HW-1:0] TOP  = HW'(HOLD_TICKS);

    logic [HW-1:0] cnt_q;
    logic          fired_q;

    assign fire_o = pressed_i && run_i && tick_i && !fired_q && (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (!pressed_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (run_i && tick_i && !fired_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                fired_q <= 1'b1;
            end
        end
    end

    // R6: release always clears the count
    p_hold_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pressed_i |=> (cnt_q == '0));

    // R5: the count saturates at the limit
    p_hold_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= TOP);

    // R6: no progress outside S0
    p_hold_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pressed_i && !run_i) |=> (cnt_q == $past(cnt_q)) || !$past(pressed_i));
endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
    import pbs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       main_pwr_i,
    input  logic       pwr_ok_i,
    input  logic       sci_en_i,
    input  logic       ring_en_i,
    input  logic       pwr_press_i,
    input  logic       slp_press_i,
    input  logic       ring_press_i,
    input  logic       sw_sleep_i,
    input  logic [2:0] sw_typ_i,
    input  logic       ovr_fire_i,
    output pstate_e    state_o,
    output logic       sci_o,
    output logic       smi_o,
    output logic       wake_o,
    output logic       ovr_o,
    output logic       slp_req_o,
    output logic       brk_o
);
    pstate_e state_q, state_d;
    logic    sci_d, smi_d, wake_d, ovr_d, slp_d, brk_d;
    logic    sci_q, smi_q, wake_q, ovr_q, slp_q, brk_q;
    logic    ring_ev;

    assign ring_ev = ring_press_i && ring_en_i;

    always_comb begin
        state_d = state_q;
        sci_d   = 1'b0;
        smi_d   = 1'b0;
        wake_d  = 1'b0;
        ovr_d   = 1'b0;
        slp_d   = 1'b0;
        brk_d   = 1'b0;
        if (!main_pwr_i) begin
            state_d = ST_G3;
        end else begin
            unique case (state_q)
                ST_G3: begin
                    state_d = ST_S5;
                end
                ST_S0: begin
                    if (ovr_fire_i) begin
                        state_d = ST_S5;
                        ovr_d   = 1'b1;
                    end else begin
                        if (pwr_press_i) begin
                            sci_d = sci_en_i;
                            smi_d = !sci_en_i;
                        end
                        slp_d = slp_press_i;
                        brk_d = ring_ev;
                        if (sw_sleep_i && pwr_ok_i && valid_sleep(sw_typ_i)) begin
                            state_d = pstate_e'(sw_typ_i);
                        end
                    end
                end
                ST_S1, ST_S2, ST_S3, ST_S4: begin
                    if (ovr_fire_i) begin
                        state_d = ST_S5;
                        ovr_d   = 1'b1;
                    end else if (pwr_press_i || slp_press_i || ring_ev) begin
                        state_d = ST_S0;
                        wake_d  = 1'b1;
                    end
                end
                ST_S5: begin
                    if (pwr_press_i || ring_ev) begin
                        state_d = ST_S0;
                        wake_d  = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_S5;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_S5;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sci_q  <= 1'b0;
            smi_q  <= 1'b0;
            wake_q <= 1'b0;
            ovr_q  <= 1'b0;
            slp_q  <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            sci_q  <= sci_d;
            smi_q  <= smi_d;
            wake_q <= wake_d;
            ovr_q  <= ovr_d;
            slp_q  <= slp_d;
            brk_q  <= brk_d;
        end
    end

    assign state_o   = state_q;
    assign sci_o     = sci_q;
    assign smi_o     = smi_q;
    assign wake_o    = wake_q;
    assign ovr_o     = ovr_q;
    assign slp_req_o = slp_q;
    assign brk_o     = brk_q;

    // R7: power loss always lands in G3
    p_g3_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !main_pwr_i |=> (state_q == ST_G3));

    // R7: nothing is reported out of G3
    p_g3_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_G3) |=> !(sci_q || smi_q || wake_q || ovr_q || slp_q || brk_q));

    // R5: an override with power present ends in S5
    p_ovr_s5_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (main_pwr_i && ovr_fire_i) |=> (state_q == ST_S5));

    // R4: a wake strobe coincides with S0
    p_wake_s0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_q |-> (state_q == ST_S0));

    // R8: the sleep button never drives the state to S5
    p_slp_not_s5_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slp_press_i && !pwr_press_i && !ovr_fire_i && !sw_sleep_i && main_pwr_i
         && state_q != ST_S5 && state_q != ST_G3) |=> (state_q != ST_S5));
endmodule

// File: rtl/pwrbtn_seq.sv
module pwrbtn_seq
    import pbs_pkg::*;
#(
    parameter int DB_TICKS   = 16,
    parameter int HOLD_TICKS = 4000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       pwr_btn_ni,
    input  logic       slp_btn_ni,
    input  logic       ring_ni,
    input  logic       main_pwr_i,
    input  logic       pwr_ok_i,
    input  logic       sci_en_i,
    input  logic       ring_en_i,
    input  logic       sw_sleep_i,
    input  logic [2:0] sw_typ_i,
    output logic [2:0] state_o,
    output logic       btn_lvl_o,
    output logic       sci_o,
    output logic       smi_o,
    output logic       wake_o,
    output logic       ovr_o,
    output logic       slp_req_o,
    output logic       brk_irq_o
);
    logic [NSRC-1:0] raw_n;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] press;
    logic            ovr_fire;
    pstate_e         cur_state;

    assign raw_n[SRC_PWR]  = pwr_btn_ni;
    assign raw_n[SRC_SLP]  = slp_btn_ni;
    assign raw_n[SRC_RING] = ring_ni;

    for (genvar g = 0; g < NSRC; g++) begin : g_db
        pbs_debounce #(.DB_TICKS(DB_TICKS)) u_db (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (tick_i),
            .raw_ni  (raw_n[g]),
            .lvl_o   (lvl[g]),
            .press_o (press[g])
        );
    end

    pbs_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .pressed_i (lvl[SRC_PWR]),
        .run_i     (cur_state == ST_S0),
        .fire_o    (ovr_fire)
    );

    pbs_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .main_pwr_i   (main_pwr_i),
        .pwr_ok_i     (pwr_ok_i),
        .sci_en_i     (sci_en_i),
        .ring_en_i    (ring_en_i),
        .pwr_press_i  (press[SRC_PWR]),
        .slp_press_i  (press[SRC_SLP]),
        .ring_press_i (press[SRC_RING]),
        .sw_sleep_i   (sw_sleep_i),
        .sw_typ_i     (sw_typ_i),
        .ovr_fire_i   (ovr_fire),
        .state_o      (cur_state),
        .sci_o        (sci_o),
        .smi_o        (smi_o),
        .wake_o       (wake_o),
        .ovr_o        (ovr_o),
        .slp_req_o    (slp_req_o),
        .brk_o        (brk_irq_o)
    );

    assign state_o   = cur_state;
    assign btn_lvl_o = lvl[SRC_PWR];
endmodule

// File: tb/sim_pwrbtn_seq.sv
`timescale 1ns/1ps
module sim_pwrbtn_seq;
    localparam int DB     = 3;
    localparam int HOLD   = 10;
    localparam int TP     = 4;
    localparam int SETTLE = 40;
    localparam int SHORT  = 24;
    localparam int LONG   = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic pbtn_n = 1'b1, sbtn_n = 1'b1, ring_n = 1'b1;
    logic mpwr = 1'b1, pok = 1'b1, scien = 1'b0, ringen = 1'b0;
    logic swsl = 1'b0;
    logic [2:0] swtyp = 3'd0;
    logic [2:0] st;
    logic lvl, sci, smi, wake, ovr, slpr, brk;

    int nchk = 0, nfail = 0;
    int c_sci = 0, c_smi = 0, c_wake = 0, c_ovr = 0, c_slp = 0, c_brk = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwrbtn_seq #(.DB_TICKS(DB), .HOLD_TICKS(HOLD)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .pwr_btn_ni(pbtn_n), .slp_btn_ni(sbtn_n), .ring_ni(ring_n),
        .main_pwr_i(mpwr), .pwr_ok_i(pok), .sci_en_i(scien), .ring_en_i(ringen),
        .sw_sleep_i(swsl), .sw_typ_i(swtyp),
        .state_o(st), .btn_lvl_o(lvl), .sci_o(sci), .smi_o(smi), .wake_o(wake),
        .ovr_o(ovr), .slp_req_o(slpr), .brk_irq_o(brk)
    );

    initial begin
        forever begin
            repeat (TP - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            c_sci  <= c_sci  + int'(sci);
            c_smi  <= c_smi  + int'(smi);
            c_wake <= c_wake + int'(wake);
            c_ovr  <= c_ovr  + int'(ovr);
            c_slp  <= c_slp  + int'(slpr);
            c_brk  <= c_brk  + int'(brk);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pwr_press(input int hold);
        pbtn_n = 1'b0; wait_n(hold); pbtn_n = 1'b1; wait_n(SETTLE);
    endtask

    task automatic slp_press();
        sbtn_n = 1'b0; wait_n(SHORT); sbtn_n = 1'b1; wait_n(SETTLE);
    endtask

    task automatic ring_pulse();
        ring_n = 1'b0; wait_n(SHORT); ring_n = 1'b1; wait_n(SETTLE);
    endtask

    task automatic sw_cmd(input logic [2:0] t);
        swtyp = t; swsl = 1'b1; wait_n(1); swsl = 1'b0; wait_n(3);
    endtask

    initial begin
        int w0, s0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        chk("R1 reset state", st, 5);
        chk("R1 reset strobes", int'(sci | smi | wake | ovr | slpr | brk), 0);
        chk("R2 reset level", lvl, 0);

        // R2 debounce timing window and R4 wake from S5
        w0 = c_wake;
        pbtn_n = 1'b0;
        wait_n((DB - 1) * TP);
        chk("R2 level early", lvl, 0);
        wait_n(TP + 10 - (DB - 1) * TP + (DB - 1) * TP - (DB - 1) * TP);
        chk("R2 level settled", lvl, 1);
        wait_n(SHORT - 18);
        pbtn_n = 1'b1; wait_n(SETTLE);
        chk("R2 level released", lvl, 0);
        chk("R4 wake from S5", c_wake - w0, 1);
        chk("R4 state S0", st, 0);

        // R2 glitch ignored
        s0 = c_sci + c_smi;
        pbtn_n = 1'b0; wait_n(2); pbtn_n = 1'b1; wait_n(SETTLE);
        chk("R2 glitch strobes", c_sci + c_smi - s0, 0);
        chk("R2 glitch state", st, 0);

        // R3 SCI versus SMI sweep
        for (int e = 0; e < 2; e++) begin
            int a, b;
            scien = e[0]; a = c_sci; b = c_smi;
            pwr_press(SHORT);
            chk("R3 sci count", c_sci - a, e);
            chk("R3 smi count", c_smi - b, 1 - e);
            chk("R3 state kept", st, 0);
        end
        chk("R5 no override on short", c_ovr, 0);

        // R10 software sleep sweep
        for (int t = 0; t < 8; t++) begin
            int expst;
            expst = (t >= 1 && t <= 5) ? t : 0;
            sw_cmd(t[2:0]);
            chk("R10 sleep target", st, expst);
            if (expst != 0) begin
                w0 = c_wake;
                pwr_press(SHORT);
                chk("R4 wake from sleep", c_wake - w0, 1);
                chk("R4 back in S0", st, 0);
            end
        end
        pok = 1'b0;
        sw_cmd(3'd3);
        chk("R10 pwr_ok low ignored", st, 0);
        pok = 1'b1;

        // R8 sleep button
        s0 = c_slp;
        slp_press();
        chk("R8 request in S0", c_slp - s0, 1);
        chk("R8 state kept", st, 0);
        sw_cmd(3'd2);
        w0 = c_wake;
        slp_press();
        chk("R8 wake from S2", c_wake - w0, 1);
        chk("R8 state after wake", st, 0);
        sw_cmd(3'd5);
        w0 = c_wake;
        slp_press();
        chk("R8 no wake from S5", c_wake - w0, 0);
        chk("R8 stays S5", st, 5);
        pwr_press(SHORT);

        // R9 ring indicate
        sw_cmd(3'd3);
        ringen = 1'b0; w0 = c_wake;
        ring_pulse();
        chk("R9 disabled in S3", st, 3);
        ringen = 1'b1;
        ring_pulse();
        chk("R9 wake from S3", c_wake - w0, 1);
        chk("R9 state S0", st, 0);
        s0 = c_brk;
        ring_pulse();
        chk("R9 break irq in S0", c_brk - s0, 1);
        ringen = 1'b0;
        ring_pulse();
        chk("R9 disabled in S0", c_brk - s0, 1);
        sw_cmd(3'd5);
        ringen = 1'b1; w0 = c_wake;
        ring_pulse();
        chk("R9 wake from S5", c_wake - w0, 1);
        ringen = 1'b0;

        // R5 override with power-good low, single strobe on long hold
        pok = 1'b0;
        pbtn_n = 1'b0; wait_n(LONG);
        chk("R5 override state", st, 5);
        chk("R5 override strobe", c_ovr, 1);
        wait_n(LONG);
        chk("R5 single strobe", c_ovr, 1);
        pbtn_n = 1'b1; wait_n(SETTLE);
        chk("R5 release no wake", st, 5);
        pok = 1'b1;
        pwr_press(SHORT);
        chk("R4 wake after override", st, 0);

        // R6 timer frozen in suspend
        pbtn_n = 1'b0; wait_n(SHORT);
        sw_cmd(3'd2);
        wait_n(LONG);
        chk("R6 no override in S2", c_ovr, 1);
        chk("R6 still S2", st, 2);
        pbtn_n = 1'b1; wait_n(SETTLE);
        chk("R6 release no wake", st, 2);
        pwr_press(SHORT);
        chk("R6 woken", st, 0);

        // R7 G3 behaviour
        mpwr = 1'b0; wait_n(3);
        chk("R7 G3 entry", st, 7);
        w0 = c_wake; s0 = c_sci + c_smi;
        pwr_press(SHORT);
        chk("R7 press ignored", c_wake - w0 + c_sci + c_smi - s0, 0);
        chk("R7 state G3", st, 7);
        pbtn_n = 1'b0; wait_n(SHORT);
        mpwr = 1'b1; wait_n(3);
        chk("R7 power return S5", st, 5);
        wait_n(LONG);
        chk("R7 no latched wake", c_wake - w0, 0);
        chk("R6 no override in S5", c_ovr, 1);
        pbtn_n = 1'b1; wait_n(SETTLE);
        pwr_press(SHORT);
        chk("R7 wake after return", c_wake - w0, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule